// File: doc/BRIEF.md
# Serial Configuration Register Write Front End

This block is the receive side of a serial-flash style slave interface, reduced to one job: loading an 8-bit volatile configuration register from the serial bus. A host pulls chip select low and shifts in a command byte and then a data byte on the serial data input, most significant bit first, one bit per rising serial-clock edge. When chip select returns high, the block decides whether the transfer was a valid configuration write. It commits the byte only when exactly sixteen edges were seen, the command matched the write opcode and the write-enable latch was already set. The commit then clears the latch.

A second command, the write-enable opcode sent as exactly one byte, sets the latch. Any other framing aborts quietly and changes nothing. The serial output stays released for the whole time. The serial pins are brought into the system clock domain through a synchronizer chain, and the register value is driven straight to an output port so that neighbouring logic sees the new setting a fixed few system clocks after chip select rises.

Top module: `spicfg_writer`

## Requirements
- R1: After reset, `cfg_value` equals the parameter `CFG_RESET` (default 8'hFF) and `wel` is 0.
- R2: Bits enter most significant bit first on rising `spi_sck` edges while `spi_csn` is low: edges 0 to 7 carry the command, edges 8 to 15 carry the data byte.
- R3: A transaction of exactly 8 edges whose command equals `OP_WREN` (default 8'h06) sets `wel` to 1 when `spi_csn` rises.
- R4: A transaction of exactly 16 edges whose command equals `OP_WRCFG` (default 8'h61), started while `wel` is 1, loads the data byte into `cfg_value` and clears `wel`.
- R5: If `spi_csn` rises after any edge count other than the exact one a command needs (fewer or more edges), `cfg_value` and `wel` both keep their values.
- R6: A correctly framed configuration write started while `wel` is 0 leaves `cfg_value` unchanged.
- R7: Any command other than the two opcodes leaves `cfg_value` and `wel` unchanged.
- R8: `sdo_oe` is 0 and `spi_sdo` is 0 at all times (the serial output is high impedance).
- R9: A committed value appears on `cfg_value` no more than `SYNC_STAGES`+1 system clock cycles after `spi_csn` rises at the pin.
- R10: While `spi_csn` is high the edge counter is cleared, so a transaction that follows an aborted one is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Chip select, active low |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo | output | 1 | Serial data to the host, held at 0 |
| sdo_oe | output | 1 | Output enable for `spi_sdo`, held at 0 |
| cfg_value | output | DATA_W | Current configuration register contents |
| wel | output | 1 | Write-enable latch state |

## Verification
A wrong edge count or a stale command byte inside the block shows up as a configuration value that changes after a short or long transfer, or as a latch that fails to set or clear. Both appear at `cfg_value` and `wel` within `SYNC_STAGES`+1 system clocks of chip select rising. A shift in the wrong direction shows up as a bit-reversed value on the same schedule. The bench therefore checks both outputs once per transaction at that fixed latency, using asymmetric data bytes so that the bit order is also checked.

// File: rtl/spicfg_pkg.sv
package spicfg_pkg;

   // Outcome of a completed transaction, decided when chip select rises.
   typedef enum logic [1:0] {
      ACT_NONE     = 2'd0,
      ACT_SET_WEL  = 2'd1,
      ACT_LOAD_CFG = 2'd2
   } spicfg_act_e;

   // Width of a counter that must hold values 0..max_val.
   function automatic int unsigned cnt_width(input int unsigned max_val);
      int unsigned w;
      w = 1;
      while ((1 << w) <= max_val) w++;
      return w;
   endfunction

endpackage

// File: rtl/spicfg_sync.sv
module spicfg_sync #(
   parameter int unsigned        WIDTH   = 3,
   parameter int unsigned        STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/spicfg_shifter.sv
module spicfg_shifter #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_idle,
   input  logic              bit_strobe,
   input  logic              bit_in,
   output logic [DATA_W-1:0] cmd_byte,
   output logic [DATA_W-1:0] data_byte,
   output logic [CNT_W-1:0]  edge_cnt
);

   localparam int unsigned    CNT_SAT  = 2 * DATA_W + 1;
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_SAT);
   localparam logic [CNT_W-1:0] CMD_END = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] shift_q;
   logic [DATA_W-1:0] shift_next;

   assign shift_next = {shift_q[DATA_W-2:0], bit_in};

   // Edge counter saturates one past the longest legal frame so that an
   // overlong transfer can never wrap back onto a legal count.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_cnt <= '0;
      end else if (cs_idle) begin
         edge_cnt <= '0;
      end else if (bit_strobe && (edge_cnt != CNT_TOP)) begin
         edge_cnt <= edge_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
      end else if (cs_idle) begin
         shift_q <= '0;
      end else if (bit_strobe) begin
         shift_q <= shift_next;
      end
   end

   // Command byte is frozen on the last command edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_byte <= '0;
      end else if (cs_idle) begin
         cmd_byte <= '0;
      end else if (bit_strobe && (edge_cnt == CMD_END)) begin
         cmd_byte <= shift_next;
      end
   end

   assign data_byte = shift_q;

endmodule

// File: rtl/spicfg_decode.sv
module spicfg_decode
   import spicfg_pkg::*;
#(
   parameter int unsigned      DATA_W   = 8,
   parameter int unsigned      CNT_W    = 5,
   parameter logic [DATA_W-1:0] OP_WRCFG = 8'h61,
   parameter logic [DATA_W-1:0] OP_WREN  = 8'h06
) (
   input  logic              frame_end,
   input  logic [DATA_W-1:0] cmd_byte,
   input  logic [CNT_W-1:0]  edge_cnt,
   input  logic              wel_now,
   output spicfg_act_e       action
);

   localparam logic [CNT_W-1:0] LEN_ONE = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] LEN_TWO = CNT_W'(2 * DATA_W);

   logic is_wren;
   logic is_wrcfg;

   assign is_wren  = (edge_cnt == LEN_ONE) && (cmd_byte == OP_WREN);
   assign is_wrcfg = (edge_cnt == LEN_TWO) && (cmd_byte == OP_WRCFG) && wel_now;

   always_comb begin
      action = ACT_NONE;
      if (frame_end) begin
         if (is_wrcfg)     action = ACT_LOAD_CFG;
         else if (is_wren) action = ACT_SET_WEL;
      end
   end

endmodule

// File: rtl/spicfg_regs.sv
module spicfg_regs
   import spicfg_pkg::*;
#(
   parameter int unsigned       DATA_W    = 8,
   parameter logic [DATA_W-1:0] CFG_RESET = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  spicfg_act_e       action,
   input  logic [DATA_W-1:0] new_value,
   output logic [DATA_W-1:0] cfg_q,
   output logic              wel_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RESET;
         wel_q <= 1'b0;
      end else begin
         unique case (action)
            ACT_LOAD_CFG: begin
               cfg_q <= new_value;
               wel_q <= 1'b0;
            end
            ACT_SET_WEL: wel_q <= 1'b1;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/spicfg_writer.sv
module spicfg_writer
   import spicfg_pkg::*;
#(
   parameter int unsigned       DATA_W      = 8,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] OP_WRCFG    = 8'h61,
   parameter logic [DATA_W-1:0] OP_WREN     = 8'h06,
   parameter logic [DATA_W-1:0] CFG_RESET   = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_csn,
   input  logic              spi_sdi,
   output logic              spi_sdo,
   output logic              sdo_oe,
   output logic [DATA_W-1:0] cfg_value,
   output logic              wel
);

   localparam int unsigned CNT_W  = cnt_width(2 * DATA_W + 1);
   localparam int unsigned PIN_N  = 3;
   localparam logic [PIN_N-1:0] PIN_RST = 3'b010;   // {sdi, csn, sck}

   // Elaboration-time parameter checks.
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("spicfg_writer: SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("spicfg_writer: DATA_W must be at least 2");
      end
      if (OP_WRCFG == OP_WREN) begin : g_bad_ops
         $error("spicfg_writer: the two opcodes must differ");
      end
   endgenerate

   logic [PIN_N-1:0] pins_s;
   logic             sck_s, csn_s, sdi_s;
   logic             sck_d, csn_d;
   logic             sck_rise, cs_rise;

   logic [DATA_W-1:0] cmd_byte;
   logic [DATA_W-1:0] data_byte;
   logic [CNT_W-1:0]  edge_cnt;
   spicfg_act_e       action;

   spicfg_sync #(
      .WIDTH   (PIN_N),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({spi_sdi, spi_csn, spi_sck}),
      .q_sync  (pins_s)
   );

   assign sck_s = pins_s[0];
   assign csn_s = pins_s[1];
   assign sdi_s = pins_s[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         csn_d <= 1'b1;
      end else begin
         sck_d <= sck_s;
         csn_d <= csn_s;
      end
   end

   assign sck_rise = sck_s & ~sck_d & ~csn_s;
   assign cs_rise  = csn_s & ~csn_d;

   spicfg_shifter #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_idle    (csn_s),
      .bit_strobe (sck_rise),
      .bit_in     (sdi_s),
      .cmd_byte   (cmd_byte),
      .data_byte  (data_byte),
      .edge_cnt   (edge_cnt)
   );

   spicfg_decode #(
      .DATA_W   (DATA_W),
      .CNT_W    (CNT_W),
      .OP_WRCFG (OP_WRCFG),
      .OP_WREN  (OP_WREN)
   ) u_dec (
      .frame_end (cs_rise),
      .cmd_byte  (cmd_byte),
      .edge_cnt  (edge_cnt),
      .wel_now   (wel),
      .action    (action)
   );

   spicfg_regs #(
      .DATA_W    (DATA_W),
      .CFG_RESET (CFG_RESET)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .action    (action),
      .new_value (data_byte),
      .cfg_q     (cfg_value),
      .wel_q     (wel)
   );

   assign spi_sdo = 1'b0;
   assign sdo_oe  = 1'b0;

endmodule

// File: rtl/spicfg_writer_chk.sv
module spicfg_writer_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              spi_csn,
   input logic              sdo_oe,
   input logic              spi_sdo,
   input logic [DATA_W-1:0] cfg_value,
   input logic              wel
);

   // R8: serial output never driven
   assert_sdo_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sdo_oe && !spi_sdo));

   // R4: a register change always clears the latch
   assert_commit_clears_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_value) |-> !wel);

   // R6: a register change needs the latch to have been set
   assert_commit_needs_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_value) |-> $past(wel));

   // R5: a register change only follows chip select being released
   assert_commit_after_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_value) |-> $past(spi_csn));

   // R3: latch set never coincides with a register change, and follows release
   assert_wel_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> ($stable(cfg_value) && $past(spi_csn)));

endmodule

bind spicfg_writer spicfg_writer_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .spi_csn   (spi_csn),
   .sdo_oe    (sdo_oe),
   .spi_sdo   (spi_sdo),
   .cfg_value (cfg_value),
   .wel       (wel)
);

// File: tb/spicfg_writer_test.sv
`timescale 1ns/1ps
module spicfg_writer_test;

   localparam int SYNC   = 2;
   localparam int HALF   = 3;     // system clocks per serial half period

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0;
   logic       csn = 1'b1;
   logic       sdi = 1'b0;
   logic       sdo, oe, wel;
   logic [7:0] cfg;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [7:0] cfg;
      logic       wel;
      string      tag;
   } exp_t;

   exp_t scb_q[$];

   logic [7:0] m_cfg;
   logic       m_wel;

   always #10 clk = ~clk;   // 50 MHz

   spicfg_writer uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .spi_sck   (sck),
      .spi_csn   (csn),
      .spi_sdi   (sdi),
      .spi_sdo   (sdo),
      .sdo_oe    (oe),
      .cfg_value (cfg),
      .wel       (wel)
   );

   task automatic check1(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Driver: send nbits from a left-aligned word, release chip select, wait the
   // commit latency, then push the model's expectation.
   task automatic xfer(input logic [31:0] word, input int nbits, input string tag);
      logic [7:0] op, dat;
      op  = word[31:24];
      dat = word[23:16];
      @(negedge clk) csn = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         sdi = word[31-i];
         sck = 1'b0;
         repeat (HALF) @(negedge clk);
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         if (i == 4) check1({tag, " R8 oe mid-frame"}, {7'd0, oe | sdo}, 8'h00);
      end
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
      csn = 1'b1;
      // reference model from the requirements
      if (nbits == 8 && op == 8'h06) m_wel = 1'b1;
      else if (nbits == 16 && op == 8'h61 && m_wel) begin
         m_cfg = dat;
         m_wel = 1'b0;
      end
      repeat (SYNC + 1) @(negedge clk);   // R9 latency bound
      scb_q.push_back('{cfg: m_cfg, wel: m_wel, tag: tag});
      repeat (8) @(negedge clk);
   endtask

   // Monitor: compare outputs against queued expectations.
   initial begin
      forever begin
         @(negedge clk);
         if (scb_q.size() > 0) begin
            exp_t e;
            e = scb_q.pop_front();
            check1({e.tag, " cfg"}, cfg, e.cfg);
            check1({e.tag, " wel"}, {7'd0, wel}, {7'd0, e.wel});
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      m_cfg = 8'hFF;
      m_wel = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check1("R1 reset cfg", cfg, 8'hFF);
      check1("R1 reset wel", {7'd0, wel}, 8'h00);
      check1("R8 reset oe", {6'd0, oe, sdo}, 8'h00);

      xfer({8'h61, 8'h5A, 16'h0}, 16, "R6 write without latch");
      xfer({8'h06, 24'h0},        8,  "R3 write enable");
      xfer({8'h61, 8'hC1, 16'h0}, 16, "R4 R9 R2 commit C1");
      xfer({8'h06, 8'h80, 16'h0}, 9,  "R5 enable overlong");
      xfer({8'h06, 24'h0},        7,  "R5 enable short");
      xfer({8'h06, 24'h0},        8,  "R3 enable again");
      xfer({8'h61, 8'h77, 16'h0}, 15, "R5 write short");
      xfer({8'h61, 8'h77, 16'h0}, 17, "R5 write overlong");
      xfer({8'h62, 8'h00, 16'h0}, 16, "R7 foreign opcode");
      xfer({8'h06, 24'h0},        4,  "R10 abort after four");
      xfer({8'h61, 8'h3C, 16'h0}, 16, "R10 R4 fresh write 3C");
      xfer({8'h06, 24'h0},        8,  "R3 enable third");
      xfer({8'h61, 8'h01, 16'h0}, 16, "R2 msb-first 01");

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule